// File: doc/BRIEF.md
# Programmable Audio Clock Divider

The block derives three audio clocks from one master audio clock. Several master clocks arrive at the block, and a source-select field picks one of them. Each master clock is presented as a one-cycle tick strobe in the fast system clock domain, with one strobe per master rising edge. A 4-bit ratio code states how many times the sample rate Fs the chosen master runs at. From that code the block produces three clocks at once: a bit clock for the biphase serial output at 128 × Fs, a bit clock for the DAC serial port at 64 × Fs, and a master clock for an external DAC at either 256 × Fs or 384 × Fs. All three clocks are registered levels that change only on selected master ticks.

One frame counter spans a single sample period of master ticks. Each output has a small phase counter, and the frame counter clears all of them together, so the output edges stay aligned. A new code, source or DAC master rate is sampled only when the frame counter wraps. This means a running clock never sees a shortened pulse. If the DAC master rate cannot be made from the current ratio as a whole number of ticks of at least two, a status output shows it and the DAC master clock stays low.

Top module: `audclk_divider`

## Requirements
- R1: While `rst_n` is low, all four outputs are low.
- R2: The serial-output bit clock has a period of ratio/128 master ticks. It is high for the first floor(period/2) ticks of each period.
- R3: The DAC bit clock has a period of ratio/64 master ticks and is high for exactly half of it.
- R4: The DAC master clock has a period of ratio/256 ticks when `mclk_384` is 0, and ratio/384 ticks when it is 1. It is high for the first floor(period/2) ticks.
- R5: The ratio codes map as follows: 0x0 gives a ratio of 256, 0x1 gives 384, 0x2 gives 512, 0x3 gives 768 and 0x4 gives 1024.
- R6: Codes 0x5 through 0xF are reserved. While a reserved code is active, all clock outputs and `dac_mclk_ok` are low.
- R7: `dac_mclk_ok` is high only when the chosen DAC master period is a whole number of ticks and at least 2. While it is low, `dac_mclk` stays low.
- R8: A change of code, source or `mclk_384` made in the middle of a frame has no effect until the tick that ends that frame. From that tick on, the new pattern starts with every clock high.
- R9: Bit i of `mclk_tick` is the tick of source i. Only ticks from the active source move the outputs, and ticks from other sources are ignored.
- R10: Every rising edge of the DAC bit clock falls in the same cycle as a rising edge of the serial-output bit clock. Whenever `dac_mclk_ok` is high, every serial-output rising edge also falls in the same cycle as a DAC master rising edge.
- R11: When a valid code is presented while a reserved code is active, it is taken at the next clock edge, and a new frame starts with all enabled clocks high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_tick | input | NSRC | Per-source master clock tick strobes, bit i = source i |
| src_sel | input | SRC_W | Requested master clock source |
| div_code | input | 4 | Requested master-to-Fs ratio code |
| mclk_384 | input | 1 | DAC master rate: 0 = 256 × Fs, 1 = 384 × Fs |
| ser_bclk | output | 1 | Serial-output bit clock, 128 × Fs |
| dac_bclk | output | 1 | DAC bit clock, 64 × Fs |
| dac_mclk | output | 1 | External DAC master clock |
| dac_mclk_ok | output | 1 | DAC master clock can be generated at the current settings |

## Verification
The hardest case to reach is a settings change made in the middle of a frame. The change must have no effect on the old clocks for hundreds of ticks and must then switch over on exactly the tick that ends the frame. To reach it, the bench resets the block with ticks on every cycle, so the frame phase follows directly from the cycle count. It changes the code partway through a 512-tick frame and then checks every sample against the old pattern up to the wrap and against the new pattern after it. The behaviour on and off the reserved codes, and ticks from a source that is not selected, are reached through a reset with those settings already in place.

// File: rtl/audclk_pkg.sv
`timescale 1ns/1ps
package audclk_pkg;

    // Ratio code range and derived counter widths
    localparam int unsigned MAX_RATIO = 1024;
    localparam int unsigned CNT_W     = $clog2(MAX_RATIO);
    localparam int unsigned RATIO_W   = CNT_W + 1;

    // Output rates as multiples of Fs
    localparam int unsigned SER_RATE  = 128;
    localparam int unsigned DAC_RATE  = 64;
    localparam int unsigned MCK_LOW   = 256;
    localparam int unsigned MCK_HIGH  = 384;

    localparam int unsigned SUB_W     = $clog2(MAX_RATIO / DAC_RATE + 1);
    localparam int unsigned NUM_OUT   = 3;
    localparam int unsigned OUT_SER   = 0;
    localparam int unsigned OUT_DAC   = 1;
    localparam int unsigned OUT_MCK   = 2;

    typedef logic [3:0]       div_code_t;
    typedef logic [SUB_W-1:0] per_t;
    typedef per_t [NUM_OUT-1:0] per_set_t;

    localparam per_t PER_MIN = per_t'(2);

    // Master-to-Fs ratio of a code; zero marks a reserved code
    function automatic logic [RATIO_W-1:0] ratio_of(div_code_t code);
        case (code)
            4'h0:    return RATIO_W'(256);
            4'h1:    return RATIO_W'(384);
            4'h2:    return RATIO_W'(512);
            4'h3:    return RATIO_W'(768);
            4'h4:    return RATIO_W'(1024);
            default: return '0;
        endcase
    endfunction

    // Tick periods of the three outputs; zero or one means not producible
    function automatic per_set_t periods_of(div_code_t code, logic k384);
        logic [RATIO_W-1:0] r;
        per_set_t           p;
        r          = ratio_of(code);
        p[OUT_SER] = per_t'(r / RATIO_W'(SER_RATE));
        p[OUT_DAC] = per_t'(r / RATIO_W'(DAC_RATE));
        if (k384) begin
            p[OUT_MCK] = ((r % RATIO_W'(MCK_HIGH)) == '0) ? per_t'(r / RATIO_W'(MCK_HIGH)) : '0;
        end else begin
            p[OUT_MCK] = per_t'(r / RATIO_W'(MCK_LOW));
        end
        return p;
    endfunction

endpackage

// File: rtl/audclk_src_mux.sv
`timescale 1ns/1ps
module audclk_src_mux #(
    parameter int unsigned NSRC  = 4,
    parameter int unsigned SRC_W = 2
) (
    input  logic [NSRC-1:0]  tick_in,
    input  logic [SRC_W-1:0] sel,
    output logic             tick_out
);

    // Pick the strobe of the active source; an unpopulated index gives no tick
    always_comb begin
        tick_out = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SRC_W'(i)) begin
                tick_out = tick_in[i];
            end
        end
    end

endmodule

// File: rtl/audclk_frame.sv
`timescale 1ns/1ps
module audclk_frame
    import audclk_pkg::*;
#(
    parameter int unsigned SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_tick,
    input  logic [SRC_W-1:0] src_sel,
    input  div_code_t        div_code,
    input  logic             k384_sel,
    output logic [SRC_W-1:0] active_src,
    output logic             frame_start,
    output per_set_t         per_next,
    output logic             mck_ok
);

    typedef struct packed {
        logic [SRC_W-1:0] src;
        div_code_t        code;
        logic             k384;
        logic [CNT_W-1:0] cnt;
    } frame_st_t;

    frame_st_t          st_d, st_q;
    logic [RATIO_W-1:0] ratio_q;
    per_set_t           per_q;

    always_comb begin
        st_d    = st_q;
        ratio_q = ratio_of(st_q.code);
        // A reserved code reloads every cycle; a valid one reloads on the last tick of a frame
        frame_start = (ratio_q == '0) ||
                      (sel_tick && ({1'b0, st_q.cnt} == (ratio_q - RATIO_W'(1))));
        if (frame_start) begin
            st_d.src  = src_sel;
            st_d.code = div_code;
            st_d.k384 = k384_sel;
            st_d.cnt  = '0;
        end else if (sel_tick) begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
        per_next = periods_of(st_d.code, st_d.k384);
        per_q    = periods_of(st_q.code, st_q.k384);
        mck_ok   = (per_q[OUT_MCK] >= PER_MIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= 4'hF;
        end else begin
            st_q      <= st_d;
        end
    end

    assign active_src = st_q.src;

endmodule

// File: rtl/audclk_phase_gen.sv
`timescale 1ns/1ps
module audclk_phase_gen
    import audclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic frame_start,
    input  per_t per_next,
    output logic clk_out
);

    typedef struct packed {
        per_t sub;
        logic level;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.sub = '0;
        end else if (tick) begin
            st_d.sub = (st_q.sub == per_next - 1'b1) ? '0 : st_q.sub + 1'b1;
        end
        // High for the first half of each period, only when the period is usable
        st_d.level = (per_next >= PER_MIN) && (st_d.sub < (per_next >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_out = st_q.level;

endmodule

// File: rtl/audclk_divider.sv
`timescale 1ns/1ps
module audclk_divider
    import audclk_pkg::*;
#(
    parameter  int unsigned NSRC  = 4,
    localparam int unsigned SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  mclk_tick,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [3:0]       div_code,
    input  logic             mclk_384,
    output logic             ser_bclk,
    output logic             dac_bclk,
    output logic             dac_mclk,
    output logic             dac_mclk_ok
);

    logic [SRC_W-1:0]   active_src;
    logic               sel_tick;
    logic               frame_start;
    per_set_t           per_next;
    logic [NUM_OUT-1:0] clk_vec;

    audclk_src_mux #(
        .NSRC  (NSRC),
        .SRC_W (SRC_W)
    ) u_mux (
        .tick_in  (mclk_tick),
        .sel      (active_src),
        .tick_out (sel_tick)
    );

    audclk_frame #(
        .SRC_W (SRC_W)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_tick    (sel_tick),
        .src_sel     (src_sel),
        .div_code    (div_code),
        .k384_sel    (mclk_384),
        .active_src  (active_src),
        .frame_start (frame_start),
        .per_next    (per_next),
        .mck_ok      (dac_mclk_ok)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        audclk_phase_gen u_gen (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (sel_tick),
            .frame_start (frame_start),
            .per_next    (per_next[g]),
            .clk_out     (clk_vec[g])
        );
    end

    assign ser_bclk = clk_vec[OUT_SER];
    assign dac_bclk = clk_vec[OUT_DAC];
    assign dac_mclk = clk_vec[OUT_MCK];

endmodule

// File: rtl/audclk_divider_chk.sv
`timescale 1ns/1ps
module audclk_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_tick,
    input logic frame_start,
    input logic ser,
    input logic dac,
    input logic mck,
    input logic ok
);

    // R1: outputs are forced low while reset is held
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!ser && !dac && !mck && !ok));

    // R7: no DAC master clock unless it is flagged producible
    assert_mclk_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mck |-> ok);

    // R10: DAC bit clock rises only together with the serial bit clock
    assert_dac_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac) |-> $rose(ser));

    // R10: serial bit clock rises only together with an enabled DAC master clock
    assert_mck_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ser) && ok) |-> $rose(mck));

    // R9: without a selected tick or a frame start the outputs hold
    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_tick && !frame_start) |=> ($stable(ser) && $stable(dac) && $stable(mck)));

endmodule

bind audclk_divider audclk_divider_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_tick    (sel_tick),
    .frame_start (frame_start),
    .ser         (ser_bclk),
    .dac         (dac_bclk),
    .mck         (dac_mclk),
    .ok          (dac_mclk_ok)
);

// File: tb/audclk_divider_bench.sv
`timescale 1ns/1ps
module audclk_divider_bench;

    localparam int NSRC = 4;
    localparam int NVEC = 8;
    // code, mclk_384, ser hi, ser lo, dac hi, dac lo, ok, mck hi, mck lo
    localparam int VEC [NVEC][9] = '{
        '{0, 0, 1, 1, 2, 2, 0, 0, 0},
        '{1, 0, 1, 2, 3, 3, 0, 0, 0},
        '{2, 0, 2, 2, 4, 4, 1, 1, 1},
        '{2, 1, 2, 2, 4, 4, 0, 0, 0},
        '{3, 0, 3, 3, 6, 6, 1, 1, 2},
        '{3, 1, 3, 3, 6, 6, 1, 1, 1},
        '{4, 0, 4, 4, 8, 8, 1, 2, 2},
        '{4, 1, 4, 4, 8, 8, 0, 0, 0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] mclk_tick = '1;
    logic [1:0]      src_sel = '0;
    logic [3:0]      div_code = 4'hF;
    logic            mclk_384 = 1'b0;
    logic            ser_bclk, dac_bclk, dac_mclk, dac_mclk_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    audclk_divider #(.NSRC(NSRC)) u_audclk_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .mclk_tick   (mclk_tick),
        .src_sel     (src_sel),
        .div_code    (div_code),
        .mclk_384    (mclk_384),
        .ser_bclk    (ser_bclk),
        .dac_bclk    (dac_bclk),
        .dac_mclk    (dac_mclk),
        .dac_mclk_ok (dac_mclk_ok)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int sig(int idx);
        case (idx)
            0:       return int'(ser_bclk);
            1:       return int'(dac_bclk);
            default: return int'(dac_mclk);
        endcase
    endfunction

    // Reset with the given settings applied; returns at a falling edge just after release
    task automatic do_reset(int code, int k, int src);
        @(negedge clk);
        rst_n    = 1'b0;
        div_code = 4'(code);
        mclk_384 = k[0];
        src_sel  = 2'(src);
        step();
        step();
        check("R1", "outputs in reset",
              int'({ser_bclk, dac_bclk, dac_mclk, dac_mclk_ok}), 0);
        rst_n = 1'b1;
    endtask

    // Measure one full high/low run of an output after its next rising edge
    task automatic measure(int idx, int exp_hi, int exp_lo, string req);
        int guard = 0;
        int hi = 0;
        int lo = 0;
        while (sig(idx) == 1 && guard < 100) begin step(); guard++; end
        while (sig(idx) == 0 && guard < 200) begin step(); guard++; end
        while (sig(idx) == 1 && hi < 100) begin step(); hi++; end
        while (sig(idx) == 0 && lo < 100) begin step(); lo++; end
        check(req, $sformatf("output %0d high ticks", idx), hi, exp_hi);
        check(req, $sformatf("output %0d low ticks", idx), lo, exp_lo);
    endtask

    initial begin
        int ones;
        int bad;

        // Table walk: every valid code with both DAC master rates (R2 R3 R4 R5 R7)
        for (int v = 0; v < NVEC; v++) begin
            mclk_tick = '1;
            do_reset(VEC[v][0], VEC[v][1], 0);
            step();
            check("R7", $sformatf("ok flag code %0d k %0d", VEC[v][0], VEC[v][1]),
                  int'(dac_mclk_ok), VEC[v][6]);
            measure(0, VEC[v][2], VEC[v][3], "R2 R5");
            measure(1, VEC[v][4], VEC[v][5], "R3 R5");
            if (VEC[v][6] == 1) begin
                measure(2, VEC[v][7], VEC[v][8], "R4");
            end else begin
                ones = 0;
                for (int i = 0; i < 40; i++) begin
                    step();
                    ones += int'(dac_mclk);
                end
                check("R7", "gated dac_mclk high samples", ones, 0);
            end
        end

        // Reserved code holds everything low (R6), then a valid code starts at once (R11)
        mclk_tick = '1;
        do_reset(9, 0, 0);
        ones = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            ones += int'(ser_bclk) + int'(dac_bclk) + int'(dac_mclk) + int'(dac_mclk_ok);
        end
        check("R6", "high samples under reserved code", ones, 0);
        div_code = 4'h2;
        step();
        check("R11", "clocks high one edge after leaving reserved",
              int'({ser_bclk, dac_bclk, dac_mclk, dac_mclk_ok}), 15);
        measure(0, 2, 2, "R11");

        // Mid-frame change from 512 to 1024 applies only at the wrap on edge 513 (R8)
        do_reset(2, 0, 0);
        for (int n = 1; n <= 100; n++) step();
        div_code = 4'h4;
        bad = 0;
        for (int n = 101; n <= 512; n++) begin
            step();
            if (int'(ser_bclk) != int'(((n - 1) % 4) < 2)) bad++;
            if (int'(dac_bclk) != int'(((n - 1) % 8) < 4)) bad++;
        end
        check("R8", "old pattern mismatches before wrap", bad, 0);
        bad = 0;
        for (int n = 513; n <= 544; n++) begin
            step();
            if (int'(ser_bclk) != int'(((n - 513) % 8) < 4)) bad++;
            if (int'(dac_bclk) != int'(((n - 513) % 16) < 8)) bad++;
        end
        check("R8", "new pattern mismatches after wrap", bad, 0);

        // Ticks on a source that is not selected are ignored (R9)
        mclk_tick = 4'b0001;
        do_reset(0, 0, 1);
        step();
        check("R9", "clocks high at frame start", int'({ser_bclk, dac_bclk}), 3);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (!ser_bclk || !dac_bclk) bad++;
        end
        check("R9", "changes on foreign ticks", bad, 0);
        mclk_tick = 4'b0010;
        step();
        check("R9", "ser_bclk after a selected tick", int'(ser_bclk), 0);
        check("R9", "dac_bclk after a selected tick", int'(dac_bclk), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule